// File: doc/BRIEF.md
# Tuning Synthesiser Two-Wire Register Slave

This block is the serial control port of a frequency synthesiser. It watches the two-wire bus (SCL and SDA) with the system clock and finds START and STOP conditions. It recognises its own address and then either accepts tuning and control bytes or returns a status byte. The tuning data is a 15-bit loop divider word. The control data covers a 3-bit test field, a 4-bit reference ratio code, a 2-bit pump current code, the reference output enable and select bits, and four port outputs. The status byte reports the power-on flag and the lock flag.

In write mode the data bytes arrive in pairs. The leading bit of the first byte of a pair tells the slave what the pair carries: 0 means the divider word, 1 means the control fields. Any number of pairs may follow one address. The divider word only changes as a whole. In read mode a missing acknowledge from the master ends the transfer at once.

Top module: `synth_i2c_regs`

## Requirements
- R1: The slave responds only to the address byte 1,1,0,0,0,A1,A0,RW (MSB first), where A1,A0 equal `addr_sel_i[1:0]`. Any other address gets no acknowledge, and the data bytes that follow it change no output.
- R2: After a matching address, the slave pulls SDA low during the acknowledge clock of the address byte and of every write data byte. `sda_pull_o` only changes while the sampled SCL is low.
- R3: In write mode, a first pair byte whose bit 7 is 0 is a divider pair. Its bits 6..0 are divider bits 14..8, and the next byte holds divider bits 7..0.
- R4: A first pair byte whose bit 7 is 1 is a control pair. Its bits 6..4 set `test_o` and bits 3..0 set `ratio_o`. In the next byte, bits 7..6 set `pump_o`, bit 5 sets `ref_en_o`, bit 4 sets `ref_sel_o` and bits 3..0 set `port_o`. Each field changes when its byte completes.
- R5: Further pairs can follow under the same address. Each pair is classified by its own first bit.
- R6: `div_o` changes only when the eighth bit of the low divider byte arrives, or at a STOP. Between the two bytes of a divider pair it keeps its old value.
- R7: A STOP after a complete high divider byte puts those 7 bits into `div_o[14:8]` and keeps `div_o[7:0]`. A partial byte before a STOP is discarded.
- R8: The read status byte is POR, FL, 0,0,0,0,0,0 with FL = `lock_i`. POR is 1 after reset and clears at the STOP that ends a read transfer.
- R9: In read mode, if SDA is high at the master acknowledge clock, the slave stops driving SDA and sends no further bits until the next START.
- R10: After reset, `div_o`, `test_o`, `ratio_o`, `pump_o` and `port_o` are 0 (all ports off), `ref_en_o` and `ref_sel_o` are 1, and SDA is released.
- R11: A repeated START aborts the current transfer, restarts address decoding and makes the next data byte the first byte of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 2 | Selected variable address bits |
| lock_i | input | 1 | Loop lock indication |
| sda_pull_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| div_o | output | 15 | Loop divider word |
| test_o | output | 3 | Test mode field |
| ratio_o | output | 4 | Reference ratio code |
| pump_o | output | 2 | Pump current code |
| ref_en_o | output | 1 | Reference output enable |
| ref_sel_o | output | 1 | Reference output select |
| port_o | output | 4 | Port outputs, 1 = active |

## Verification
If the pair-tracking bit is wrong, a control byte lands in the divider fields, or the reverse. That shows up on the register outputs within a few clocks of the eighth SCL rise. If staging or the STOP commit is wrong, `div_o` moves early, or fails to move, at the byte or STOP edge. A wrong POR flag or read-abort state is visible on the sampled SDA line during the next status byte or the clock after a NACK. The bench compares every output against a behavioural model on every clock outside a short settle window after each bus event.

// File: rtl/synth_i2c_regs.sv
module synth_i2c_regs #(
  parameter logic [4:0] DEV_ID = 5'b11000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  addr_sel_i,
  input  logic        lock_i,
  output logic        sda_pull_o,
  output logic [14:0] div_o,
  output logic [2:0]  test_o,
  output logic [3:0]  ratio_o,
  output logic [1:0]  pump_o,
  output logic        ref_en_o,
  output logic        ref_sel_o,
  output logic [3:0]  port_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_WDAT, S_RDAT, S_RACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  st_t        st;
  logic [2:0] bcnt;
  logic [6:0] shr;
  logic [7:0] tx;
  logic       rw, ack_on, second, ctrl_pair;
  logic [6:0] hi_stage;
  logic       hi_pend, rd_seen, por_q;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire [7:0] rx_byte = {shr, sda_s};
  wire byte_end = scl_rise & (bcnt == 3'd7);
  wire addr_ok = (rx_byte[7:3] == DEV_ID) & (rx_byte[2:1] == addr_sel_i);
  wire [7:0] status = {por_q, lock_i, 6'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bcnt <= '0;
      shr <= '0;
      tx <= '0;
      rw <= 1'b0;
      ack_on <= 1'b0;
      second <= 1'b0;
      ctrl_pair <= 1'b0;
      hi_stage <= '0;
      hi_pend <= 1'b0;
      rd_seen <= 1'b0;
      por_q <= 1'b1;
      sda_pull_o <= 1'b0;
      div_o <= '0;
      test_o <= '0;
      ratio_o <= '0;
      pump_o <= '0;
      ref_en_o <= 1'b1;
      ref_sel_o <= 1'b1;
      port_o <= '0;
    end else if (start_det) begin
      st <= S_ADDR;
      bcnt <= '0;
      second <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE;
      sda_pull_o <= 1'b0;
      if (hi_pend) begin
        div_o <= {hi_stage, div_o[7:0]};
        hi_pend <= 1'b0;
      end
      if (rd_seen) begin
        por_q <= 1'b0;
        rd_seen <= 1'b0;
      end
    end else begin
      case (st)
        S_ADDR: if (scl_rise) begin
          shr <= rx_byte[6:0];
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            ack_on <= 1'b0;
            rw <= sda_s;
            st <= addr_ok ? S_ACK : S_IDLE;
          end
        end
        S_ACK: if (scl_fall) begin
          if (!ack_on) begin
            ack_on <= 1'b1;
            sda_pull_o <= 1'b1;
          end else begin
            ack_on <= 1'b0;
            bcnt <= '0;
            if (rw) begin
              st <= S_RDAT;
              tx <= status;
              sda_pull_o <= ~status[7];
              rd_seen <= 1'b1;
            end else begin
              st <= S_WDAT;
              sda_pull_o <= 1'b0;
            end
          end
        end
        S_WDAT: if (scl_rise) begin
          shr <= rx_byte[6:0];
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            st <= S_ACK;
            ack_on <= 1'b0;
            if (!second) begin
              second <= 1'b1;
              ctrl_pair <= rx_byte[7];
              if (rx_byte[7]) begin
                test_o <= rx_byte[6:4];
                ratio_o <= rx_byte[3:0];
              end else begin
                hi_stage <= rx_byte[6:0];
                hi_pend <= 1'b1;
              end
            end else begin
              second <= 1'b0;
              if (ctrl_pair) begin
                pump_o <= rx_byte[7:6];
                ref_en_o <= rx_byte[5];
                ref_sel_o <= rx_byte[4];
                port_o <= rx_byte[3:0];
              end else begin
                div_o <= {hi_stage, rx_byte};
                hi_pend <= 1'b0;
              end
            end
          end
        end
        S_RDAT: begin
          if (scl_fall) begin
            tx <= {tx[6:0], 1'b0};
            sda_pull_o <= ~tx[6];
          end else if (scl_rise) begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              st <= S_RACK;
              ack_on <= 1'b0;
            end
          end
        end
        S_RACK: begin
          if (scl_fall && !ack_on) begin
            sda_pull_o <= 1'b0;
            ack_on <= 1'b1;
          end else if (scl_rise && ack_on && sda_s) begin
            st <= S_IDLE;
          end else if (scl_fall && ack_on) begin
            ack_on <= 1'b0;
            bcnt <= '0;
            tx <= status;
            sda_pull_o <= ~status[7];
            st <= S_RDAT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NO_ACK_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && byte_end && !addr_ok && !start_det && !stop_det) |=> !sda_pull_o); // R1
  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !$past(scl_s)); // R2
  AST_CTRL_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pump_o, ref_en_o, ref_sel_o, port_o}) |-> $past(st == S_WDAT && byte_end)); // R4
  AST_DIV_COMMIT_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_o) |-> $past(stop_det || (st == S_WDAT && byte_end))); // R6
  AST_POR_CLEAR_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(stop_det)); // R8
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && ack_on && scl_rise && sda_s && !start_det && !stop_det) |=> (st == S_IDLE && !sda_pull_o)); // R9

endmodule

// File: tb/synth_i2c_regs_tb.sv
module synth_i2c_regs_tb_top;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_rel = 1'b1;
  logic [1:0] ma = 2'b00;
  logic lock = 1'b0;
  logic pull;
  logic [14:0] div;
  logic [2:0] test;
  logic [3:0] ratio, port;
  logic [1:0] pump;
  logic re, rs;
  wire sda_line = m_rel & ~pull;

  always #4 clk = ~clk;

  synth_i2c_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel_i(ma), .lock_i(lock), .sda_pull_o(pull), .div_o(div),
    .test_o(test), .ratio_o(ratio), .pump_o(pump), .ref_en_o(re),
    .ref_sel_o(rs), .port_o(port));

  int checks = 0, fails = 0, settle = 4;
  string cur_req = "R10";

  logic [14:0] m_div = '0;
  logic [2:0] m_test = '0;
  logic [3:0] m_ratio = '0, m_port = '0;
  logic [1:0] m_pump = '0;
  logic m_re = 1'b1, m_rs = 1'b1, m_por = 1'b1;
  logic [6:0] pend_q[$];
  bit m_second = 0, m_ctrl = 0, m_wr = 0, m_rd_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (settle > 0) settle--;
    else if (rst_n)
      chk({div, test, ratio, pump, re, rs, port} ==
          {m_div, m_test, m_ratio, m_pump, m_re, m_rs, m_port}, cur_req, "regs",
          {2'b0, div, test, ratio, pump, re, rs, port},
          {2'b0, m_div, m_test, m_ratio, m_pump, m_re, m_rs, m_port});
  end

  task automatic model_byte(input logic [7:0] b);
    if (!m_second) begin
      m_second = 1; m_ctrl = b[7];
      if (b[7]) begin m_test = b[6:4]; m_ratio = b[3:0]; end
      else begin pend_q.delete(); pend_q.push_back(b[6:0]); end
    end else begin
      m_second = 0;
      if (m_ctrl) begin m_pump = b[7:6]; m_re = b[5]; m_rs = b[4]; m_port = b[3:0]; end
      else m_div = {pend_q.pop_front(), b};
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic start_c;
    m_rel = 1; wt(Q); m_scl = 1; wt(Q); m_rel = 0; wt(Q); m_scl = 0; wt(Q);
    m_second = 0; m_wr = 0;
  endtask

  task automatic stop_c;
    m_rel = 0; wt(Q); m_scl = 1; wt(Q); m_rel = 1; settle = 8;
    if (pend_q.size() > 0) m_div = {pend_q.pop_front(), m_div[7:0]};
    if (m_rd_seen) m_por = 0;
    m_rd_seen = 0; m_wr = 0;
    wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_rel = b[i]; wt(Q); m_scl = 1;
      if (i == 0 && m_wr) begin settle = 8; model_byte(b); end
      wt(Q); m_scl = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_rel = 1; wt(Q); m_scl = 1; wt(Q / 2); ack = ~sda_line; wt(Q / 2); m_scl = 0;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    m_rel = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_scl = 1; wt(Q / 2); b[i] = sda_line; wt(Q / 2); m_scl = 0;
    end
    m_rel = ~mack; wt(Q); m_scl = 1; wt(Q); m_scl = 0; wt(2); m_rel = 1;
  endtask

  task automatic address(input logic [7:0] a);
    bit ack, hit;
    hit = (a[7:3] == 5'b11000) && (a[2:1] == ma);
    start_c();
    send_byte(a, ack);
    chk(ack == hit, hit ? "R2" : "R1", "address ack", {31'b0, ack}, {31'b0, hit});
    m_wr = hit && !a[0];
    if (hit && a[0]) m_rd_seen = 1;
  endtask

  task automatic wr(input logic [7:0] b, input string req);
    bit ack;
    cur_req = req;
    send_byte(b, ack);
    chk(ack == m_wr, "R2", "data ack", {31'b0, ack}, {31'b0, m_wr});
  endtask

  task automatic rd_status(input bit mack);
    logic [7:0] b;
    read_byte(mack, b);
    chk(b == {m_por, lock, 6'b0}, "R8", "status byte", {24'b0, b}, {24'b0, m_por, lock, 6'b0});
  endtask

  initial begin
    wt(5);
    chk(pull == 1'b0 && div == 0 && port == 0 && re && rs, "R10", "reset state",
        {15'b0, pull, div, re, rs}, {15'b0, 1'b0, 15'b0, 2'b11});
    rst_n = 1; wt(10);

    cur_req = "R1";
    address(8'hC2); wr(8'h8F, "R1"); wr(8'hFF, "R1"); stop_c();

    address(8'hC0); wr(8'h35, "R6"); wr(8'hA7, "R3"); stop_c();
    address(8'hC0); wr(8'hD6, "R4"); wr(8'h95, "R4"); stop_c();

    ma = 2'b10;
    address(8'hC4); wr(8'h0F, "R5"); wr(8'h11, "R5"); wr(8'hA3, "R5");
    wr(8'h6A, "R5"); wr(8'h7F, "R5"); wr(8'hFF, "R5"); stop_c();

    address(8'hC4); wr(8'h2B, "R7"); cur_req = "R7"; stop_c();
    address(8'hC4); wr(8'h55, "R7"); send_bits(8'h3C, 4); cur_req = "R7"; stop_c();

    address(8'hC4); wr(8'h8F, "R11");
    address(8'hC4); wr(8'h12, "R11"); wr(8'h34, "R11"); stop_c();

    cur_req = "R8";
    lock = 1; address(8'hC5); rd_status(1);
    lock = 0; rd_status(1);
    rd_status(0);
    begin
      logic [7:0] b;
      read_byte(0, b);
      chk(b == 8'hFF, "R9", "line released after nack", {24'b0, b}, 32'hFF);
    end
    stop_c();
    lock = 1; address(8'hC5); rd_status(0); stop_c();
    address(8'hC0); stop_c();
    wt(40);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule